// File: doc/BRIEF.md
# Run-Time Configurable Pin Bank

A bank of general-purpose pins whose behaviour is chosen at run time by single-cycle commands. Each command carries an operation, a pin index and one argument byte. One argument byte in a configure command fixes the pin's whole role. That role covers its direction, its pull resistor, push-pull or open-drain drive, its starting level, or the edge that raises an interrupt event. A pin can also be handed over to a pulse-width modulator whose duty cycle is written as a whole percentage. Software can later change an output's level or ask for the current level of any pin.

The bank drives per-pin output value, output enable and pull-up and pull-down controls toward the pad ring. It takes the raw pad levels back through a two-stage synchronizer. The serial transport that delivers the commands and the pads themselves sit outside the block. Commands are accepted one per cycle with no back-pressure. A level query answers exactly one cycle later.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a GPIO input with no pull: pad_oe, pad_out, pull_up, pull_dn, irq_event and rd_valid are all 0, and every stored PWM duty is 0.
- R2: Configure command (cmd_op=0) with argument 0x01 makes the pin an input with no pull, 0x10 an input with pull_dn=1, and 0x11 an input with pull_up=1; pulls are asserted only on GPIO inputs and never both at once.
- R3: Configure argument 0x20 or 0x21 makes the pin a push-pull output (pad_oe=1) whose level starts at argument bit 0.
- R4: Configure argument 0x40 or 0x41 makes the pin open-drain with starting level from bit 0: level 0 gives pad_oe=1 and pad_out=0, level 1 gives pad_oe=0.
- R5: Configure argument 0x80, 0x81 or 0x82 makes the pin an undriven interrupt input that pulses irq_event for one cycle on a rising, falling or either edge of the synchronized pad level, two clocks after the pad change is first sampled.
- R6: A configure argument not listed in R2 to R5 leaves the pin's configuration unchanged.
- R7: Set command (cmd_op=1) stores argument bit 0 as the pin's output level, which reaches the pad at once in push-pull or open-drain mode.
- R8: Get command (cmd_op=2) raises rd_valid for exactly the next cycle, with rd_level equal to the PWM wave for a PWM pin, the stored level for an output, or the synchronized pad level otherwise.
- R9: Alternate-function command (cmd_op=4) with argument 0x01 hands the pin to the PWM with duty 0 (pad driven low). Argument 0x00 returns the pin to its reset state as a GPIO input with no pull. Any other argument is ignored.
- R10: Duty command (cmd_op=3) stores a percentage, clamped to 100. A PWM pin drives high while the shared phase counter is below the duty. The phase counter runs through 0 to 99 and advances once every PRESCALE clocks.
- R11: Commands whose pin index is NUM_PINS or larger, and operation codes 5 to 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation: 0 configure, 1 set, 2 get, 3 duty, 4 alternate function |
| cmd_pin | input | 8 | Target pin index |
| cmd_arg | input | 8 | Argument byte |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |
| pull_up | output | NUM_PINS | Pull-up request |
| pull_dn | output | NUM_PINS | Pull-down request |
| irq_event | output | NUM_PINS | One-cycle edge event per pin |
| rd_valid | output | 1 | Level query answer is valid |
| rd_level | output | 1 | Answered pin level |

## Verification
Nearly all pin state is visible at the ports within one cycle of the command that set it. A wrong mode, pull or level therefore shows on pad_oe, pad_out or the pull lines at the very next comparison. A wrong edge selection or synchronizer depth shows only when the pad toggles, as an irq_event missing, extra or a cycle late. A wrong prescaler, phase wrap or duty clamp shows as a PWM edge at the wrong cycle within one 100-tick period.

// File: rtl/gpio_bank_pkg.sv
// Shared types for the pin bank: operation codes, pin roles and the
// per-pin configuration record with its decode of configure arguments.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        OP_CONFIG = 3'd0,
        OP_SET    = 3'd1,
        OP_GET    = 3'd2,
        OP_DUTY   = 3'd3,
        OP_ALT    = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        PM_INPUT, PM_PUSHPULL, PM_OPENDRAIN, PM_IRQ
    } pin_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE, PULL_DOWN, PULL_UP
    } pull_e;

    typedef enum logic [1:0] {
        EDGE_RISE, EDGE_FALL, EDGE_ANY
    } edge_e;

    typedef struct packed {
        pin_mode_e  mode;
        pull_e      pull;
        edge_e      edge_sel;
        logic       level;
        logic       alt_pwm;
        logic [6:0] duty;
    } pin_state_t;

    localparam pin_state_t PIN_RESET = '{
        mode: PM_INPUT, pull: PULL_NONE, edge_sel: EDGE_RISE,
        level: 1'b0, alt_pwm: 1'b0, duty: 7'd0
    };

    localparam logic [6:0] DUTY_MAX = 7'd100;

    // Applies one configure argument byte; unknown codes return cur unchanged.
    function automatic pin_state_t apply_config(pin_state_t cur, logic [7:0] code);
        pin_state_t nxt;
        nxt = cur;
        unique case (code)
            8'h01: begin nxt.mode = PM_INPUT; nxt.pull = PULL_NONE; end
            8'h10: begin nxt.mode = PM_INPUT; nxt.pull = PULL_DOWN; end
            8'h11: begin nxt.mode = PM_INPUT; nxt.pull = PULL_UP;   end
            8'h20, 8'h21: begin
                nxt.mode = PM_PUSHPULL; nxt.pull = PULL_NONE; nxt.level = code[0];
            end
            8'h40, 8'h41: begin
                nxt.mode = PM_OPENDRAIN; nxt.pull = PULL_NONE; nxt.level = code[0];
            end
            8'h80: begin nxt.mode = PM_IRQ; nxt.pull = PULL_NONE; nxt.edge_sel = EDGE_RISE; end
            8'h81: begin nxt.mode = PM_IRQ; nxt.pull = PULL_NONE; nxt.edge_sel = EDGE_FALL; end
            8'h82: begin nxt.mode = PM_IRQ; nxt.pull = PULL_NONE; nxt.edge_sel = EDGE_ANY;  end
            default: ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Two-flop synchronizer for all pad inputs plus one history stage for
// edge detection. Assumes pad_in may change asynchronously to clk.
module gpio_bank_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] sync_lvl,
    output logic [NUM_PINS-1:0] prev_lvl
);
    logic [NUM_PINS-1:0] meta_q;

    // Shifts pad levels through the metastability and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_lvl <= '0;
            prev_lvl <= '0;
        end else begin
            meta_q   <= pad_in;
            sync_lvl <= meta_q;
            prev_lvl <= sync_lvl;
        end
    end
endmodule

// File: rtl/gpio_bank_timebase.sv
// Shared PWM timebase: a prescaler of PRESCALE clocks feeding a phase
// counter that wraps after 100 ticks. Assumes PRESCALE >= 1.
module gpio_bank_timebase #(
    parameter int PRESCALE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [6:0] phase
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [6:0]    PHASE_LAST = 7'd99;

    logic [PW-1:0] pre_q;

    // Advances the phase once per completed prescaler count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            phase <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            phase <= (phase == PHASE_LAST) ? 7'd0 : phase + 7'd1;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/gpio_bank_pin.sv
// One pin slice: holds the pin's configuration record, applies commands
// addressed to it and derives its pad controls, edge event and read level.
// Assumes at most one command per cycle and pre-synchronized inputs.
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [2:0] op,
    input  logic [7:0] arg,
    input  logic [6:0] phase,
    input  logic       sync_lvl,
    input  logic       prev_lvl,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pull_up,
    output logic       pull_dn,
    output logic       irq_event,
    output logic       level_rd
);
    pin_state_t st;
    logic       wave;
    logic       rise, fall;

    // Applies a command targeted at this pin to its configuration record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PIN_RESET;
        end else if (hit) begin
            case (op)
                OP_CONFIG: st <= apply_config(st, arg);
                OP_SET:    st.level <= arg[0];
                OP_DUTY:   st.duty <= (arg > 8'(DUTY_MAX)) ? DUTY_MAX : arg[6:0];
                OP_ALT: begin
                    if (arg == 8'h00) begin
                        st <= PIN_RESET;
                    end else if (arg == 8'h01) begin
                        st.alt_pwm <= 1'b1;
                        st.duty    <= 7'd0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Computes the PWM wave and the edges of the synchronized input.
    always_comb begin
        wave = (phase < st.duty);
        rise = sync_lvl & ~prev_lvl;
        fall = ~sync_lvl & prev_lvl;
    end

    // Maps the current role onto pad controls, edge event and read level.
    always_comb begin
        pad_out   = 1'b0;
        pad_oe    = 1'b0;
        pull_up   = 1'b0;
        pull_dn   = 1'b0;
        irq_event = 1'b0;
        level_rd  = sync_lvl;
        if (st.alt_pwm) begin
            pad_oe   = 1'b1;
            pad_out  = wave;
            level_rd = wave;
        end else begin
            unique case (st.mode)
                PM_INPUT: begin
                    pull_up = (st.pull == PULL_UP);
                    pull_dn = (st.pull == PULL_DOWN);
                end
                PM_PUSHPULL: begin
                    pad_oe   = 1'b1;
                    pad_out  = st.level;
                    level_rd = st.level;
                end
                PM_OPENDRAIN: begin
                    pad_oe   = ~st.level;
                    level_rd = st.level;
                end
                PM_IRQ: begin
                    unique case (st.edge_sel)
                        EDGE_RISE: irq_event = rise;
                        EDGE_FALL: irq_event = fall;
                        default:   irq_event = rise | fall;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Top of the pin bank: decodes the target pin of each command, hosts one
// pin slice per pin, the shared synchronizer and PWM timebase, and
// registers the answer to level queries. Assumes NUM_PINS in 2..255.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PRESCALE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [7:0]          cmd_pin,
    input  logic [7:0]          cmd_arg,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pull_up,
    output logic [NUM_PINS-1:0] pull_dn,
    output logic [NUM_PINS-1:0] irq_event,
    output logic                rd_valid,
    output logic                rd_level
);
    localparam int         IDX_W     = $clog2(NUM_PINS);
    localparam logic [7:0] PIN_LIMIT = 8'(NUM_PINS);

    logic [NUM_PINS-1:0] sync_lvl, prev_lvl, level_rd;
    logic [6:0]          phase;
    logic                pin_ok;

    assign pin_ok = cmd_pin < PIN_LIMIT;

    gpio_bank_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .sync_lvl(sync_lvl), .prev_lvl(prev_lvl)
    );

    gpio_bank_timebase #(.PRESCALE(PRESCALE)) i_timebase (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_bank_pin i_pin (
            .clk(clk), .rst_n(rst_n),
            .hit(cmd_valid && (cmd_pin == 8'(i))),
            .op(cmd_op), .arg(cmd_arg), .phase(phase),
            .sync_lvl(sync_lvl[i]), .prev_lvl(prev_lvl[i]),
            .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
            .pull_up(pull_up[i]), .pull_dn(pull_dn[i]),
            .irq_event(irq_event[i]), .level_rd(level_rd[i])
        );
    end

    // Registers the answer to a level query one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_level <= 1'b0;
        end else if (cmd_valid && cmd_op == OP_GET && pin_ok) begin
            rd_valid <= 1'b1;
            rd_level <= level_rd[cmd_pin[IDX_W-1:0]];
        end else begin
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Port-level properties of the pin bank, bound onto every instance.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic [7:0]          cmd_pin,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pull_up,
    input logic [NUM_PINS-1:0] pull_dn,
    input logic [NUM_PINS-1:0] irq_event,
    input logic                rd_valid
);
    logic query;
    assign query = cmd_valid && cmd_op == OP_GET && cmd_pin < 8'(NUM_PINS);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pull_up == '0 && pull_dn == '0 && !rd_valid));

    p_pull_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_dn) == '0);

    p_pull_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up | pull_dn) & pad_oe) == '0);

    p_irq_undriven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event & pad_oe) == '0);

    p_query_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        query |=> rd_valid);

    p_query_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !query |=> !rd_valid);

    p_bad_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_pin >= 8'(NUM_PINS))
        |=> ($stable(pad_oe) && $stable(pull_up) && $stable(pull_dn)));
endmodule

bind gpio_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS)) i_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pin(cmd_pin), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .irq_event(irq_event), .rd_valid(rd_valid)
);

// File: tb/test_gpio_bank.sv
// Bench: behavioural per-cycle model compared against every output at
// each falling edge; stimulus changes only at falling edges.
module test_gpio_bank;
    localparam int N  = 8;
    localparam int PS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [7:0]   cmd_pin = '0;
    logic [7:0]   cmd_arg = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pull_up, pull_dn, irq_event;
    logic         rd_valid, rd_level;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    done     = 0;

    always #2 clk = ~clk;

    gpio_bank #(.NUM_PINS(N), .PRESCALE(PS)) i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pin(cmd_pin), .cmd_arg(cmd_arg), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
        .irq_event(irq_event), .rd_valid(rd_valid), .rd_level(rd_level)
    );

    // Model state. mode: 0 input, 1 push-pull, 2 open-drain, 3 irq.
    // pull: 0 none, 1 down, 2 up. edge: 0 rise, 1 fall, 2 any.
    int m_mode[N], m_pull[N], m_edge[N], m_lvl[N], m_alt[N], m_duty[N];
    int m_s1[N], m_s2[N], m_prev[N];
    int m_pre, m_phase, m_rdv, m_rdl;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_mode[i] = 0; m_pull[i] = 0; m_edge[i] = 0; m_lvl[i] = 0;
            m_alt[i] = 0; m_duty[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        end
        m_pre = 0; m_phase = 0; m_rdv = 0; m_rdl = 0;
    endtask

    function automatic int wave(int i);
        return (m_phase < m_duty[i]) ? 1 : 0;
    endfunction

    function automatic int read_level(int i);
        if (m_alt[i] != 0) return wave(i);
        if (m_mode[i] == 1 || m_mode[i] == 2) return m_lvl[i];
        return m_s2[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int p, a;
            p = cmd_pin; a = cmd_arg;
            m_rdv = 0;
            if (cmd_valid && cmd_op == 3'd2 && p < N) begin
                m_rdv = 1; m_rdl = read_level(p);
            end
            if (cmd_valid && p < N) begin
                case (cmd_op)
                    3'd0: case (a)
                        'h01: begin m_mode[p] = 0; m_pull[p] = 0; end
                        'h10: begin m_mode[p] = 0; m_pull[p] = 1; end
                        'h11: begin m_mode[p] = 0; m_pull[p] = 2; end
                        'h20, 'h21: begin m_mode[p] = 1; m_pull[p] = 0; m_lvl[p] = a % 2; end
                        'h40, 'h41: begin m_mode[p] = 2; m_pull[p] = 0; m_lvl[p] = a % 2; end
                        'h80, 'h81, 'h82: begin m_mode[p] = 3; m_pull[p] = 0; m_edge[p] = a - 'h80; end
                        default: ;
                    endcase
                    3'd1: m_lvl[p] = a % 2;
                    3'd3: m_duty[p] = (a > 100) ? 100 : a;
                    3'd4: if (a == 0) begin
                              m_mode[p] = 0; m_pull[p] = 0; m_edge[p] = 0; m_lvl[p] = 0;
                              m_alt[p] = 0; m_duty[p] = 0;
                          end else if (a == 1) begin
                              m_alt[p] = 1; m_duty[p] = 0;
                          end
                    default: ;
                endcase
            end
            for (int i = 0; i < N; i++) begin
                m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pad_in[i];
            end
            if (m_pre == PS - 1) begin
                m_pre = 0; m_phase = (m_phase == 99) ? 0 : m_phase + 1;
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compares every output with the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] e_out, e_oe, e_pu, e_pd, e_irq;
            for (int i = 0; i < N; i++) begin
                int r, f;
                e_out[i] = 0; e_oe[i] = 0; e_pu[i] = 0; e_pd[i] = 0; e_irq[i] = 0;
                r = m_s2[i] & ~m_prev[i] & 1;
                f = ~m_s2[i] & m_prev[i] & 1;
                if (m_alt[i] != 0) begin
                    e_oe[i] = 1; e_out[i] = wave(i) != 0;
                end else case (m_mode[i])
                    0: begin e_pu[i] = (m_pull[i] == 2); e_pd[i] = (m_pull[i] == 1); end
                    1: begin e_oe[i] = 1; e_out[i] = m_lvl[i] != 0; end
                    2: e_oe[i] = (m_lvl[i] == 0);
                    default: e_irq[i] = (m_edge[i] == 0) ? (r != 0) :
                                        (m_edge[i] == 1) ? (f != 0) : ((r | f) != 0);
                endcase
            end
            check("pad_out", pad_out, e_out);
            check("pad_oe", pad_oe, e_oe);
            check("pull_up", pull_up, e_pu);
            check("pull_dn", pull_dn, e_pd);
            check("irq_event", irq_event, e_irq);
            check("rd_valid", rd_valid, m_rdv);
            if (m_rdv != 0) check("rd_level", rd_level, m_rdl);
        end
    end

    task automatic cmd(int op, int pin, int arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pin = 8'(pin); cmd_arg = 8'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pad(int pin, bit v);
        @(negedge clk);
        pad_in[pin] = v;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; idle(3);
        tag = "R2"; cmd(0, 0, 'h10); cmd(0, 1, 'h11); cmd(0, 1, 'h01); idle(2);
        tag = "R3"; cmd(0, 3, 'h21); idle(1); cmd(0, 3, 'h20); idle(1); cmd(0, 1, 'h21);
        tag = "R4"; cmd(0, 4, 'h40); idle(1); cmd(0, 4, 'h41); idle(1);
        tag = "R7"; cmd(1, 3, 1); cmd(1, 4, 0); cmd(1, 4, 1); cmd(1, 0, 1); idle(1);
        tag = "R6"; cmd(0, 3, 'h33); cmd(0, 3, 'hFF); cmd(0, 0, 'h12); idle(1);
        tag = "R8"; set_pad(0, 1); idle(3); cmd(2, 0, 0); cmd(2, 3, 0); cmd(2, 4, 0);
        set_pad(0, 0); cmd(2, 0, 0); idle(2); cmd(2, 0, 0);
        tag = "R5"; cmd(0, 5, 'h80); cmd(0, 6, 'h81); cmd(0, 7, 'h82);
        set_pad(5, 1); set_pad(6, 1); set_pad(7, 1); idle(4);
        set_pad(5, 0); set_pad(6, 0); set_pad(7, 0); idle(4);
        tag = "R9"; cmd(4, 2, 1); idle(3); cmd(4, 2, 7); idle(2);
        tag = "R10"; cmd(3, 2, 50); idle(220); cmd(2, 2, 0); cmd(3, 2, 150); idle(30);
        cmd(3, 2, 1); idle(210); cmd(3, 2, 0); idle(20);
        tag = "R9"; cmd(3, 2, 30); cmd(4, 2, 0); idle(3); cmd(4, 5, 1); idle(2);
        tag = "R11"; cmd(0, 9, 'h21); cmd(4, 200, 1); cmd(5, 0, 'h21); cmd(7, 1, 0);
        cmd(2, 8, 0); idle(3);
        finish_run();
    end
endmodule